// File: doc/BRIEF.md
# Supply-Aware Processor Reset Generator

This block drives the active-low reset of a processor in a power-sequencing controller. It watches the per-rail power-good flags, the analog enable comparator, the shutdown request, the shared fault line, the sequencer's completion flag and the undervoltage-lockout flag. Reset is pulled low on the clock edge that follows any asserting condition. Because of this, a controlled power-down pulls the processor into reset before any rail has started to fall.

Reset is let go only after every condition has been clear, without a break, for a timeout period. The timeout comes from a two-bit mode select:

- a short default delay of about 10 µs;
- a long fixed delay of about 128 ms;
- a programmable delay, which is the short base plus an extra tick count.

All counts are derived from the clock frequency by parameters. The mode and the extra count are captured when a countdown begins. A change to them part way through a countdown therefore has no effect on that countdown.

All pins are plain level control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `supply_reset_gen`

## Requirements
- R1: `sys_rst_n` is 0 while `rst_n` is low. Whenever `uvlo` is 1 at a rising edge, `sys_rst_n` is 0 after that edge.
- R2: If any bit of `rail_ok` is 0 at a rising edge, `sys_rst_n` is 0 after that edge.
- R3: If `ana_en` is 0 or `shdn_n` is 0 at a rising edge, `sys_rst_n` is 0 after that edge. This applies even while every rail is still good.
- R4: If `fault_n` is 0 at a rising edge, `sys_rst_n` is 0 after that edge.
- R5: While `seq_done` is 0, `sys_rst_n` stays 0, even when all other conditions are clear.
- R6: Let edge 1 be the first rising edge at which all conditions are clear, and let L be the timeout in cycles. `sys_rst_n` rises at edge L+1, provided the conditions stay clear through that edge. With `tmo_sel` = 2'b00, L = SHORT_CYC = (CLK_HZ/1000)*SHORT_US/1000.
- R7: With `tmo_sel` = 2'b01, L = LONG_CYC = (CLK_HZ/1000)*LONG_MS.
- R8: With `tmo_sel` = 2'b10, L = SHORT_CYC + `tmo_extra`. With `tmo_sel` = 2'b11, L = SHORT_CYC and `tmo_extra` is ignored.
- R9: `tmo_sel` and `tmo_extra` are sampled at edge 1. Later changes to them do not alter the release edge of that countdown.
- R10: If any condition returns before release, the countdown is discarded. The full timeout restarts from the next edge at which all conditions are clear.
- R11: Once released, `sys_rst_n` stays 1 for as long as all conditions remain clear. Changes to `tmo_sel` or `tmo_extra` do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| uvlo | input | 1 | Undervoltage lockout active |
| rail_ok | input | NRAIL | Per-rail power-good flags, 1 = above threshold |
| ana_en | input | 1 | Analog enable above its threshold |
| shdn_n | input | 1 | Active-low shutdown request |
| fault_n | input | 1 | Active-low shared fault line |
| seq_done | input | 1 | All sequenced rails have come up |
| tmo_sel | input | 2 | Timeout mode: 00 short, 01 long, 10 programmable, 11 short |
| tmo_extra | input | PROG_W | Extra ticks added in programmable mode |
| sys_rst_n | output | 1 | Active-low processor reset |

## Verification
A vector table steps through every mode value with several extra counts, including zero and the maximum. For each vector, the bench counts the exact release edge. This separates an off-by-one in the counter, a wrong mode decode, and an extra count that leaks into modes that should ignore it.

Directed tests drop each asserting input, one at a time, after release. This shows that every input on its own forces reset on the next edge, including shutdown and enable while all rails are still good.

Two further patterns cover the countdown itself. The first changes the mode and extra count in the middle of a countdown, to show that they were captured. The second pulses a fault in the middle of a countdown, to show that the full timeout restarts rather than resuming.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;
  typedef enum logic [1:0] {
    TMO_SHORT = 2'b00,
    TMO_LONG  = 2'b01,
    TMO_PROG  = 2'b10,
    TMO_ALT   = 2'b11
  } tmo_mode_e;
endpackage

// File: rtl/rst_sup_cond.sv
module rst_sup_cond #(
  parameter int NRAIL = 4
) (
  input  logic             uvlo,
  input  logic [NRAIL-1:0] rail_ok,
  input  logic             ana_en,
  input  logic             shdn_n,
  input  logic             fault_n,
  input  logic             seq_done,
  output logic             hold
);
  // Any single condition holds the processor in reset.
  always_comb begin
    hold = uvlo | ~(&rail_ok) | ~ana_en | ~shdn_n | ~fault_n | ~seq_done;
  end
endmodule

// File: rtl/rst_sup_limit.sv
module rst_sup_limit
  import rst_sup_pkg::*;
#(
  parameter int CW        = 24,
  parameter int PROG_W    = 16,
  parameter int SHORT_CYC = 1000,
  parameter int LONG_CYC  = 12800000
) (
  input  logic [1:0]        tmo_sel,
  input  logic [PROG_W-1:0] tmo_extra,
  output logic [CW-1:0]     tgt
);
  tmo_mode_e mode;

  always_comb begin
    mode = tmo_mode_e'(tmo_sel);
    unique case (mode)
      TMO_LONG: tgt = CW'(LONG_CYC);
      TMO_PROG: tgt = CW'(SHORT_CYC) + CW'(tmo_extra);
      default:  tgt = CW'(SHORT_CYC);
    endcase
  end
endmodule

// File: rtl/rst_sup_timer.sv
module rst_sup_timer #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [CW-1:0] tgt,
  output logic          por_n
);
  logic          por_q;
  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_q   <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      lim_q   <= '0;
    end else if (hold) begin
      por_q   <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      lim_q   <= tgt;
      cnt_q   <= CW'(1);
    end else if (!por_q) begin
      if (cnt_q >= lim_q) por_q <= 1'b1;
      else                cnt_q <= cnt_q + CW'(1);
    end
  end

  assign por_n = por_q;

  // R2
  hold_forces_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !por_q);

  // R6
  no_early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_q) |-> (cnt_q == lim_q));

  // R9
  limit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(armed_q)) |-> $stable(lim_q));

  // R10
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0 && !armed_q));

  // R11
  stay_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (por_q && !hold) |=> por_q);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q <= lim_q));
endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen #(
  parameter int NRAIL    = 4,
  parameter int PROG_W   = 16,
  parameter int CLK_HZ   = 100000000,
  parameter int SHORT_US = 10,
  parameter int LONG_MS  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uvlo,
  input  logic [NRAIL-1:0]  rail_ok,
  input  logic              ana_en,
  input  logic              shdn_n,
  input  logic              fault_n,
  input  logic              seq_done,
  input  logic [1:0]        tmo_sel,
  input  logic [PROG_W-1:0] tmo_extra,
  output logic              sys_rst_n
);
  localparam int SHORT_RAW = (CLK_HZ / 1000) * SHORT_US / 1000;
  localparam int LONG_RAW  = (CLK_HZ / 1000) * LONG_MS;
  localparam int SHORT_CYC = (SHORT_RAW < 1) ? 1 : SHORT_RAW;
  localparam int LONG_CYC  = (LONG_RAW < 1) ? 1 : LONG_RAW;
  localparam int PROG_MAX  = SHORT_CYC + (1 << PROG_W) - 1;
  localparam int MAX_CYC   = (LONG_CYC > PROG_MAX) ? LONG_CYC : PROG_MAX;
  localparam int CW        = $clog2(MAX_CYC + 1);

  logic          hold;
  logic [CW-1:0] tgt;

  rst_sup_cond #(.NRAIL(NRAIL)) u_cond (
    .uvlo     (uvlo),
    .rail_ok  (rail_ok),
    .ana_en   (ana_en),
    .shdn_n   (shdn_n),
    .fault_n  (fault_n),
    .seq_done (seq_done),
    .hold     (hold)
  );

  rst_sup_limit #(
    .CW        (CW),
    .PROG_W    (PROG_W),
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
  ) u_limit (
    .tmo_sel   (tmo_sel),
    .tmo_extra (tmo_extra),
    .tgt       (tgt)
  );

  rst_sup_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (hold),
    .tgt   (tgt),
    .por_n (sys_rst_n)
  );

  // R1
  uvlo_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> !sys_rst_n);

  // R3
  shdn_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn_n || !ana_en) |=> !sys_rst_n);

  // R4
  fault_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |=> !sys_rst_n);

  // R5
  seq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_done |=> !sys_rst_n);
endmodule

// File: tb/sim_supply_reset_gen.sv
module sim_supply_reset_gen;
  localparam int NRAIL = 4;
  localparam int PW    = 8;
  localparam int SHORT = 4;     // (400000/1000)*10/1000
  localparam int LONG  = 6400;  // (400000/1000)*16

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvlo = 1'b1;
  logic [NRAIL-1:0] rail_ok = '0;
  logic ana_en = 1'b0, shdn_n = 1'b1, fault_n = 1'b1, seq_done = 1'b0;
  logic [1:0] tmo_sel = 2'b00;
  logic [PW-1:0] tmo_extra = '0;
  logic sys_rst_n;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  supply_reset_gen #(
    .NRAIL(NRAIL), .PROG_W(PW), .CLK_HZ(400000), .SHORT_US(10), .LONG_MS(16)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .rail_ok(rail_ok), .ana_en(ana_en),
    .shdn_n(shdn_n), .fault_n(fault_n), .seq_done(seq_done),
    .tmo_sel(tmo_sel), .tmo_extra(tmo_extra), .sys_rst_n(sys_rst_n)
  );

  // {mode, extra, expected release edge = L+1}
  localparam logic [25:0] VEC [0:6] = '{
    {2'd0, 8'd0,   16'd5},
    {2'd0, 8'd200, 16'd5},
    {2'd2, 8'd0,   16'd5},
    {2'd2, 8'd7,   16'd12},
    {2'd2, 8'd255, 16'd260},
    {2'd3, 8'd9,   16'd5},
    {2'd1, 8'd0,   16'd6401}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic all_clear();
    uvlo = 1'b0; rail_ok = '1; ana_en = 1'b1; shdn_n = 1'b1;
    fault_n = 1'b1; seq_done = 1'b1;
  endtask

  task automatic force_hold();
    @(negedge clk);
    fault_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_release(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!sys_rst_n && n < 20000);
  endtask

  int n;

  initial begin
    repeat (3) @(negedge clk);
    check(sys_rst_n == 1'b0, "R1 in reset", int'(sys_rst_n), 0);
    rst_n = 1'b1;
    all_clear();
    uvlo = 1'b1;
    repeat (10) @(negedge clk);
    check(sys_rst_n == 1'b0, "R1 uvlo held", int'(sys_rst_n), 0);

    // R6 R7 R8: table walk
    for (int i = 0; i < 7; i++) begin
      force_hold();
      tmo_sel   = VEC[i][25:24];
      tmo_extra = VEC[i][23:16];
      all_clear();
      wait_release(n);
      check(n == int'(VEC[i][15:0]), $sformatf("R6/R7/R8 vec%0d", i), n, int'(VEC[i][15:0]));
    end

    // R11: stays released, extra/mode changes have no effect
    tmo_sel = 2'b10; tmo_extra = 8'd3;
    repeat (50) @(negedge clk);
    check(sys_rst_n == 1'b1, "R11 stays released", int'(sys_rst_n), 1);

    // R1: uvlo after release
    tmo_sel = 2'b00; tmo_extra = '0;
    uvlo = 1'b1; @(posedge clk); @(negedge clk);
    check(sys_rst_n == 1'b0, "R1 uvlo asserts", int'(sys_rst_n), 0);
    all_clear(); wait_release(n);

    // R2: each rail
    for (int r = 0; r < NRAIL; r++) begin
      rail_ok[r] = 1'b0; @(posedge clk); @(negedge clk);
      check(sys_rst_n == 1'b0, $sformatf("R2 rail %0d", r), int'(sys_rst_n), 0);
      all_clear(); wait_release(n);
    end

    // R3: enable and shutdown with rails good
    ana_en = 1'b0; @(posedge clk); @(negedge clk);
    check(sys_rst_n == 1'b0, "R3 enable low", int'(sys_rst_n), 0);
    all_clear(); wait_release(n);
    shdn_n = 1'b0; @(posedge clk); @(negedge clk);
    check(sys_rst_n == 1'b0, "R3 shutdown low", int'(sys_rst_n), 0);
    all_clear(); wait_release(n);

    // R4: fault
    fault_n = 1'b0; @(posedge clk); @(negedge clk);
    check(sys_rst_n == 1'b0, "R4 fault low", int'(sys_rst_n), 0);
    all_clear(); wait_release(n);

    // R5: sequencing not complete blocks release
    seq_done = 1'b0; @(posedge clk); @(negedge clk);
    check(sys_rst_n == 1'b0, "R5 seq_done low", int'(sys_rst_n), 0);
    repeat (20) @(negedge clk);
    check(sys_rst_n == 1'b0, "R5 still held", int'(sys_rst_n), 0);
    seq_done = 1'b1;
    wait_release(n);
    check(n == SHORT + 1, "R5 release after seq_done", n, SHORT + 1);

    // R9: capture at start of countdown
    force_hold();
    tmo_sel = 2'b10; tmo_extra = 8'd20;
    all_clear();
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    tmo_sel = 2'b00; tmo_extra = 8'd0;
    wait_release(n);
    check(n + 2 == SHORT + 21, "R9 captured limit", n + 2, SHORT + 21);

    // R10: restart on interruption
    force_hold();
    tmo_sel = 2'b10; tmo_extra = 8'd10;
    all_clear();
    repeat (8) begin @(posedge clk); @(negedge clk); end
    fault_n = 1'b0; @(posedge clk); @(negedge clk);
    check(sys_rst_n == 1'b0, "R10 interrupted", int'(sys_rst_n), 0);
    fault_n = 1'b1;
    wait_release(n);
    check(n == SHORT + 11, "R10 full restart", n, SHORT + 11);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule